// File: doc/BRIEF.md
# Conversion Cycle Sequencer

This block runs in the conversion clock domain and schedules every timed cycle of a successive-approximation converter. A single-cycle start strobe, qualified by a two-bit operation code, launches one of three cycle types. A conversion is an acquisition window of selectable length followed by a fixed conversion budget, during which a sign decision and then the magnitude bits are taken from an external comparator bit. A self-calibration cycle and an auto-zero cycle each follow a short synchronisation delay and then run a fixed count of clocks; the arithmetic those cycles would perform is not modelled here.

One active-low busy flag covers every cycle type, including power-down. Its rising edge marks the end of a cycle, and a one-cycle done strobe marks normal completion. An abort strobe cancels the running cycle at once. If a start is presented in the same cycle, a fresh cycle begins instead. A power-down pin overrides everything else. After the pin is released, a bounded power-up wait has to elapse before the flag rises again.

Top module: `cvt_sequencer`

## Requirements
- R1: While reset is asserted, and after it is released, `eoc_o` is 1, `done_o` is 0 and `result_o` is 0.
- R2: With `eoc_o` high, a start with `op_i`=00 (conversion) and `lo_res_i`=0 drives `eoc_o` low from the next cycle. It stays low for exactly A+44 cycles, where A is 6, 10, 18 or 34 for `acq_sel_i` = 0, 1, 2 or 3.
- R3: A conversion with `lo_res_i`=1 keeps `eoc_o` low for exactly A+21 cycles.
- R4: The first conversion cycle samples `cmp_i` as the sign and places it in `result_o[12]`. Each following cycle samples one magnitude bit, MSB first. At 12 bits they fill `result_o[11:0]`. At 8 bits they fill `result_o[7:0]` and `result_o[11:8]` reads 0. Later samples are ignored.
- R5: A start with `op_i`=01 (self-calibration) keeps `eoc_o` low for exactly 2+4944 cycles and leaves `result_o` unchanged.
- R6: A start with `op_i`=10 (auto-zero) keeps `eoc_o` low for exactly 2+76 cycles and leaves `result_o` unchanged.
- R7: `done_o` is high for exactly one cycle, in the first cycle that `eoc_o` is high again after a cycle that completes normally.
- R8: When `abort_i` is given during a cycle with no start, `eoc_o` is high in the next cycle, `done_o` stays low, and `result_o` keeps its previous value.
- R9: When `abort_i` and a start arrive in the same cycle during a running cycle, a new cycle begins. Its full length and result are counted from that start.
- R10: A start without abort while a cycle is running is ignored: the running cycle keeps its length and completes normally.
- R11: While `pd_i` is high, `eoc_o` is low from the next cycle, and starts are ignored. A conversion cut short by `pd_i` commits nothing. After `pd_i` falls, `eoc_o` stays low for exactly PWRUP_CYC cycles (default 2000), then rises without a done pulse.
- R12: A start with `op_i`=11 is ignored and `eoc_o` stays high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Conversion clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Single-cycle command strobe |
| abort_i | input | 1 | Cancel the running cycle |
| pd_i | input | 1 | Power-down pin, high = powered down |
| op_i | input | 2 | 00 convert, 01 calibrate, 10 auto-zero, 11 none |
| lo_res_i | input | 1 | 1 = 8-bit magnitude conversion, 0 = 12-bit |
| acq_sel_i | input | 2 | Acquisition length select (6/10/18/34 clocks) |
| cmp_i | input | 1 | Comparator decision for the current step |
| eoc_o | output | 1 | Low while busy; rising edge ends a cycle |
| done_o | output | 1 | One-cycle strobe on normal completion |
| result_o | output | 13 | Sign (bit 12) and magnitude result |

## Verification
The critical overlap is an abort and a start in the same clock, which the sequencer must treat as a restart rather than a return to idle. The bench starts a conversion, lets it run into its comparison phase, and then raises both strobes together. It then requires the busy time to equal a full fresh conversion counted from the coincident cycle, and the result to hold the new comparator pattern. A second overlap is a power-down request arriving mid-conversion together with a later start. This is judged by the busy flag staying low, no done pulse, an unchanged result and an exact power-up count.

// File: rtl/cvt_pkg.sv
package cvt_pkg;

  typedef enum logic [1:0] {
    OP_CONVERT = 2'b00,
    OP_CALIB   = 2'b01,
    OP_ZERO    = 2'b10,
    OP_NONE    = 2'b11
  } op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ACQ,
    ST_SAR,
    ST_SYNC,
    ST_LONG,
    ST_PDN,
    ST_PWRUP
  } st_e;

  // acquisition window: 6, 10, 18, 34 clocks
  function automatic int unsigned acq_cycles(input logic [1:0] sel);
    return (32'd4 << sel) + 32'd2;
  endfunction

endpackage

// File: rtl/cvt_timer.sv
module cvt_timer #(
  parameter int W = 13
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  output logic         zero_o
);

  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_en;

  always_comb begin
    cnt_en = load_i | (cnt_q != '0);
    cnt_d  = load_i ? load_val_i : (cnt_q - 1'b1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/cvt_sar.sv
module cvt_sar #(
  parameter int MAG_W = 12,
  parameter int LO_W  = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         en_i,
  input  logic         lo_i,
  input  logic         cmp_i,
  input  logic         commit_i,
  output logic [MAG_W:0] result_o
);

  localparam int SW = $clog2(MAG_W + 2);

  logic [MAG_W:0]  work_q, work_d, res_q;
  logic [SW-1:0]   step_q, step_d, mag_n;
  logic            step_en;

  assign mag_n   = lo_i ? SW'(LO_W) : SW'(MAG_W);
  assign step_en = clr_i | (en_i & (step_q <= mag_n));
  assign step_d  = clr_i ? '0 : (step_q + 1'b1);

  // sign decided at step 0
  assign work_d[MAG_W] = clr_i ? 1'b0 :
                         (en_i && step_q == '0) ? cmp_i : work_q[MAG_W];

  // magnitude bit b decided at step (mag_n - b), MSB first
  for (genvar b = 0; b < MAG_W; b++) begin : g_mag
    logic hit;
    assign hit = en_i && (SW'(b) < mag_n) && (step_q == (mag_n - SW'(b)));
    assign work_d[b] = clr_i ? 1'b0 : (hit ? cmp_i : work_q[b]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      work_q <= '0;
      step_q <= '0;
    end else begin
      work_q <= work_d;
      if (step_en) step_q <= step_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       res_q <= '0;
    else if (commit_i) res_q <= work_d;
  end

  assign result_o = res_q;

endmodule

// File: rtl/cvt_ctrl.sv
module cvt_ctrl
  import cvt_pkg::*;
#(
  parameter int TW          = 13,
  parameter int HI_CONV_CYC = 44,
  parameter int LO_CONV_CYC = 21,
  parameter int CAL_CYC     = 4944,
  parameter int AZ_CYC      = 76,
  parameter int SYNC_DLY    = 2,
  parameter int PWRUP_CYC   = 2000
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          abort_i,
  input  logic          pd_i,
  input  logic [1:0]    op_i,
  input  logic          lo_res_i,
  input  logic [1:0]    acq_sel_i,
  input  logic          tmr_zero_i,
  output logic          tmr_load_o,
  output logic [TW-1:0] tmr_val_o,
  output logic          sar_clr_o,
  output logic          sar_en_o,
  output logic          sar_commit_o,
  output logic          lo_cfg_o,
  output logic          eoc_o,
  output logic          done_o,
  output logic          pwr_phase_o
);

  st_e  st_q, st_d;
  logic cfg_lo_q, cfg_lo_d;
  logic cfg_az_q, cfg_az_d;
  logic eoc_q, done_q, fin;
  logic kick, busy;

  always_comb begin
    st_d         = st_q;
    cfg_lo_d     = cfg_lo_q;
    cfg_az_d     = cfg_az_q;
    tmr_load_o   = 1'b0;
    tmr_val_o    = '0;
    sar_clr_o    = 1'b0;
    sar_en_o     = 1'b0;
    sar_commit_o = 1'b0;
    fin          = 1'b0;
    kick = start_i && (op_i != OP_NONE);
    busy = (st_q == ST_ACQ) || (st_q == ST_SAR) ||
           (st_q == ST_SYNC) || (st_q == ST_LONG);

    if (pd_i) begin
      st_d = ST_PDN;
    end else if (kick && ((st_q == ST_IDLE) || (busy && abort_i))) begin
      tmr_load_o = 1'b1;
      if (op_i == OP_CONVERT) begin
        st_d      = ST_ACQ;
        tmr_val_o = TW'(acq_cycles(acq_sel_i) - 1);
        sar_clr_o = 1'b1;
        cfg_lo_d  = lo_res_i;
      end else begin
        st_d      = ST_SYNC;
        tmr_val_o = TW'(SYNC_DLY - 1);
        cfg_az_d  = (op_i == OP_ZERO);
      end
    end else if (busy && abort_i) begin
      st_d = ST_IDLE;
    end else begin
      unique case (st_q)
        ST_ACQ: if (tmr_zero_i) begin
          st_d       = ST_SAR;
          tmr_load_o = 1'b1;
          tmr_val_o  = cfg_lo_q ? TW'(LO_CONV_CYC - 1) : TW'(HI_CONV_CYC - 1);
        end
        ST_SAR: begin
          sar_en_o = 1'b1;
          if (tmr_zero_i) begin
            st_d         = ST_IDLE;
            sar_commit_o = 1'b1;
            fin          = 1'b1;
          end
        end
        ST_SYNC: if (tmr_zero_i) begin
          st_d       = ST_LONG;
          tmr_load_o = 1'b1;
          tmr_val_o  = cfg_az_q ? TW'(AZ_CYC - 1) : TW'(CAL_CYC - 1);
        end
        ST_LONG: if (tmr_zero_i) begin
          st_d = ST_IDLE;
          fin  = 1'b1;
        end
        ST_PDN: begin
          st_d       = ST_PWRUP;
          tmr_load_o = 1'b1;
          tmr_val_o  = TW'(PWRUP_CYC - 1);
        end
        ST_PWRUP: if (tmr_zero_i) st_d = ST_IDLE;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_IDLE;
      cfg_lo_q <= 1'b0;
      cfg_az_q <= 1'b0;
      eoc_q    <= 1'b1;
      done_q   <= 1'b0;
    end else begin
      st_q     <= st_d;
      cfg_lo_q <= cfg_lo_d;
      cfg_az_q <= cfg_az_d;
      eoc_q    <= (st_d == ST_IDLE);
      done_q   <= fin;
    end
  end

  assign lo_cfg_o    = cfg_lo_q;
  assign eoc_o       = eoc_q;
  assign done_o      = done_q;
  assign pwr_phase_o = (st_q == ST_PDN) || (st_q == ST_PWRUP);

endmodule

// File: rtl/cvt_sequencer.sv
module cvt_sequencer #(
  parameter int MAG_W       = 12,
  parameter int LO_W        = 8,
  parameter int HI_CONV_CYC = 44,
  parameter int LO_CONV_CYC = 21,
  parameter int CAL_CYC     = 4944,
  parameter int AZ_CYC      = 76,
  parameter int SYNC_DLY    = 2,
  parameter int PWRUP_CYC   = 2000
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           start_i,
  input  logic           abort_i,
  input  logic           pd_i,
  input  logic [1:0]     op_i,
  input  logic           lo_res_i,
  input  logic [1:0]     acq_sel_i,
  input  logic           cmp_i,
  output logic           eoc_o,
  output logic           done_o,
  output logic [MAG_W:0] result_o
);

  localparam int LONGEST = (CAL_CYC > PWRUP_CYC) ? CAL_CYC : PWRUP_CYC;
  localparam int TW      = $clog2(LONGEST + 1);

  logic [1:0]    rsync_q;
  logic          rst_n_int;
  logic          tmr_load, tmr_zero;
  logic [TW-1:0] tmr_val;
  logic          sar_clr, sar_en, sar_commit, lo_cfg, pwr_phase;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rsync_q <= '0;
    else         rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_n_int = rsync_q[1];

  cvt_ctrl #(
    .TW(TW), .HI_CONV_CYC(HI_CONV_CYC), .LO_CONV_CYC(LO_CONV_CYC),
    .CAL_CYC(CAL_CYC), .AZ_CYC(AZ_CYC), .SYNC_DLY(SYNC_DLY), .PWRUP_CYC(PWRUP_CYC)
  ) u_ctrl (
    .clk_i(clk_i), .rst_ni(rst_n_int),
    .start_i(start_i), .abort_i(abort_i), .pd_i(pd_i),
    .op_i(op_i), .lo_res_i(lo_res_i), .acq_sel_i(acq_sel_i),
    .tmr_zero_i(tmr_zero), .tmr_load_o(tmr_load), .tmr_val_o(tmr_val),
    .sar_clr_o(sar_clr), .sar_en_o(sar_en), .sar_commit_o(sar_commit),
    .lo_cfg_o(lo_cfg), .eoc_o(eoc_o), .done_o(done_o), .pwr_phase_o(pwr_phase)
  );

  cvt_timer #(.W(TW)) u_timer (
    .clk_i(clk_i), .rst_ni(rst_n_int),
    .load_i(tmr_load), .load_val_i(tmr_val), .zero_o(tmr_zero)
  );

  cvt_sar #(.MAG_W(MAG_W), .LO_W(LO_W)) u_sar (
    .clk_i(clk_i), .rst_ni(rst_n_int),
    .clr_i(sar_clr), .en_i(sar_en), .lo_i(lo_cfg), .cmp_i(cmp_i),
    .commit_i(sar_commit), .result_o(result_o)
  );

endmodule

// File: rtl/cvt_sequencer_chk.sv
module cvt_sequencer_chk #(
  parameter int RW = 13
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          abort,
  input logic          pd,
  input logic [1:0]    op,
  input logic          eoc,
  input logic          done,
  input logic [RW-1:0] result,
  input logic          pwr_phase
);

  // R7: done only on the cycle eoc returns high
  p_done_on_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $rose(eoc));

  // R7: done is a single-cycle pulse
  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8: the result moves only together with done
  p_result_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(result) |-> done);

  // R8: a lone abort returns to idle without completion
  p_abort_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (abort && !start && !pd && !eoc && !pwr_phase) |=> (eoc && !done));

  // R11: power-down holds the busy flag low
  p_pd_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
    pd |=> !eoc);

  // R2: a valid start from idle leaves idle
  p_start_leaves_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && eoc && !pd && op != 2'b11) |=> !eoc);

  // R12: the empty opcode is ignored
  p_none_ignored_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (start && eoc && !pd && op == 2'b11) |=> eoc);

endmodule

bind cvt_sequencer cvt_sequencer_chk #(.RW(MAG_W + 1)) u_chk (
  .clk(clk_i), .rst_n(rst_n_int), .start(start_i), .abort(abort_i),
  .pd(pd_i), .op(op_i), .eoc(eoc_o), .done(done_o), .result(result_o),
  .pwr_phase(pwr_phase)
);

// File: tb/sim_cvt_sequencer.sv
`timescale 1ns/1ps
module sim_cvt_sequencer;

  logic        clk = 1'b0;
  logic        rst_n, start, abort, pd, lo, cmp;
  logic [1:0]  op, acq;
  logic        eoc, done;
  logic [12:0] result;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  cvt_sequencer u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .abort_i(abort), .pd_i(pd),
    .op_i(op), .lo_res_i(lo), .acq_sel_i(acq), .cmp_i(cmp),
    .eoc_o(eoc), .done_o(done), .result_o(result)
  );

  // {op, lo, acq, comparator pattern (step0 at bit 12), busy length, result}
  localparam logic [43:0] TBL [8] = '{
    {2'd0, 1'b0, 2'd0, 13'h1ABC, 13'd50,   13'h1ABC},
    {2'd0, 1'b0, 2'd1, 13'h0555, 13'd54,   13'h0555},
    {2'd0, 1'b0, 2'd2, 13'h1FFF, 13'd62,   13'h1FFF},
    {2'd0, 1'b0, 2'd3, 13'h0000, 13'd78,   13'h0000},
    {2'd0, 1'b1, 2'd0, 13'h1A5F, 13'd27,   13'h10A5},
    {2'd0, 1'b1, 2'd3, 13'h0C3F, 13'd55,   13'h00C3},
    {2'd1, 1'b0, 2'd0, 13'h1FFF, 13'd4946, 13'h00C3},
    {2'd2, 1'b0, 2'd3, 13'h1FFF, 13'd78,   13'h00C3}
  };

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  task automatic do_cycle(input logic [1:0] o, input logic l, input logic [1:0] a,
                          input logic [12:0] pat, input int exp_len,
                          input logic [12:0] exp_res, input bit with_abort,
                          input string tag);
    int c;
    int n;
    int s;
    int al;
    al = (4 << a) + 2;
    @(negedge clk);
    op = o; lo = l; acq = a; start = 1'b1; abort = with_abort;
    @(negedge clk);
    start = 1'b0; abort = 1'b0;
    c = 1; n = 0;
    while (eoc == 1'b0 && n < 6000) begin
      n++;
      s = c - 1 - al;
      cmp = (s >= 0 && s <= 12) ? pat[12-s] : 1'b0;
      @(negedge clk);
      c++;
    end
    chk(n == exp_len, {tag, " busy length"}, n, exp_len);
    chk(done == 1'b1, {tag, " R7 done at eoc rise"}, done, 1);
    chk(result == exp_res, {tag, " result"}, result, exp_res);
    @(negedge clk);
    chk(done == 1'b0, {tag, " R7 done single cycle"}, done, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired (all requirements) actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int n;
    rst_n = 1'b0; start = 0; abort = 0; pd = 0; lo = 0; cmp = 0; op = 0; acq = 0;
    repeat (3) @(negedge clk);
    chk(eoc == 1'b1 && done == 1'b0 && result == 13'h0, "R1 in reset", eoc, 1);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(eoc == 1'b1 && done == 1'b0 && result == 13'h0, "R1 after release", eoc, 1);

    for (int i = 0; i < 8; i++) begin
      string tag;
      if (TBL[i][43:42] == 2'd1)      tag = "R5 calibrate";
      else if (TBL[i][43:42] == 2'd2) tag = "R6 auto-zero";
      else if (TBL[i][41])            tag = "R3 R4 8-bit conversion";
      else                            tag = "R2 R4 12-bit conversion";
      do_cycle(TBL[i][43:42], TBL[i][41], TBL[i][40:39], TBL[i][38:26],
               int'(TBL[i][25:13]), TBL[i][12:0], 1'b0, tag);
    end

    // R8: lone abort mid-conversion
    @(negedge clk); op = 0; lo = 0; acq = 3; start = 1;
    @(negedge clk); start = 0;
    repeat (20) @(negedge clk);
    abort = 1;
    @(negedge clk); abort = 0;
    chk(eoc == 1'b1, "R8 eoc after abort", eoc, 1);
    chk(done == 1'b0, "R8 no done after abort", done, 0);
    repeat (3) @(negedge clk);
    chk(result == 13'h00C3, "R8 result kept", result, 13'h00C3);

    // R9: abort and start in the same cycle restart the conversion
    @(negedge clk); op = 0; lo = 0; acq = 0; start = 1; cmp = 1;
    @(negedge clk); start = 0;
    repeat (10) @(negedge clk);
    do_cycle(2'd0, 1'b0, 2'd0, 13'h0A5A, 50, 13'h0A5A, 1'b1, "R9 restart");

    // R10: start while busy is ignored
    @(negedge clk); op = 0; lo = 0; acq = 0; start = 1; cmp = 0;
    @(negedge clk); start = 0;
    begin
      int c;
      c = 1; n = 0;
      while (eoc == 1'b0 && n < 6000) begin
        n++;
        if (c == 5) begin start = 1; acq = 3; end
        else start = 0;
        @(negedge clk);
        c++;
      end
    end
    start = 0;
    chk(n == 50, "R10 busy length unchanged", n, 50);
    chk(result == 13'h0, "R10 result", result, 0);

    // R12: empty opcode
    @(negedge clk); op = 3; start = 1;
    @(negedge clk); start = 0;
    chk(eoc == 1'b1, "R12 eoc stays high", eoc, 1);
    @(negedge clk);
    chk(eoc == 1'b1 && done == 1'b0, "R12 no cycle", eoc, 1);

    // R11: power-down in mid-conversion, start ignored, exact power-up
    @(negedge clk); op = 0; lo = 0; acq = 0; start = 1; cmp = 1;
    @(negedge clk); start = 0;
    repeat (8) @(negedge clk);
    pd = 1;
    @(negedge clk);
    chk(eoc == 1'b0, "R11 eoc low in power-down", eoc, 0);
    repeat (5) @(negedge clk);
    start = 1;
    @(negedge clk); start = 0;
    chk(eoc == 1'b0, "R11 start ignored in power-down", eoc, 0);
    repeat (3) @(negedge clk);
    pd = 0;
    begin
      int dn;
      dn = 0; n = 0;
      @(negedge clk);
      while (eoc == 1'b0 && n < 5000) begin
        n++;
        if (done) dn++;
        @(negedge clk);
      end
      chk(n == 2000, "R11 power-up length", n, 2000);
      chk(dn == 0 && done == 1'b0, "R11 no done on power-up", dn, 0);
    end
    chk(result == 13'h0, "R11 cut conversion not committed", result, 0);

    do_cycle(2'd0, 1'b1, 2'd1, 13'h1F3C, 31, 13'h10F3, 1'b0, "R3 after power-up");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule